// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Manager

This block is a bus manager for a pipelined AHB-Lite style interconnect that performs one atomic read-modify-write on a single word address per start request. A request carries an address, an operation code and an operand. The block issues a locked NONSEQ read of the address, then a locked NONSEQ write back to the same address, and finally an IDLE cycle with the lock released. The IDLE cycle is also the data phase of the write. The value written is computed from the word that was read. Typical uses are a semaphore test-and-set (set-bits with operand 1) and a counter increment (add with operand 1).

The read data phase overlaps the write address phase. The write address goes out straight after the read address phase completes. The new value is computed at the edge where the read data is sampled with ready high, and it is driven on the write-data bus for the whole write data phase. Ready low stretches any phase and holds every address and control output. When the write data phase completes, a one-cycle done pulse is given together with the word that was read. With no request pending, the bus shows IDLE with the lock low.

Top module: `ahb_locked_rmw`

## Requirements
- R1: While reset is high and in the first cycle after it, htrans is IDLE (2'b00), hmastlock, hwrite, done and busy are low.
- R2: A start seen while busy is low is accepted. In the next cycle htrans is NONSEQ (2'b10), hwrite is 0, hmastlock is 1, haddr equals the request address and busy is 1.
- R3: In the cycle after the read address phase completes (hready high), htrans is NONSEQ, hwrite is 1, hmastlock is 1 and haddr is unchanged.
- R4: In the cycle after the write address phase completes, htrans is IDLE and hmastlock is 0. hwdata carries the new value and stays unchanged until that write data phase completes.
- R5: The new value depends on req_op: 2'b00 gives the operand (swap), 2'b01 gives old + operand modulo 2^DATA_W, 2'b10 gives old OR operand, and 2'b11 gives old AND NOT operand.
- R6: While hready is low during a NONSEQ address phase, htrans, haddr, hwrite and hmastlock hold their values.
- R7: In the cycle after the write data phase completes, done is 1 for exactly one cycle, old_data equals the word read and busy is 0.
- R8: A start asserted while busy is 1 has no effect: the running sequence keeps its address, operation and operand.
- R9: With no request pending, htrans is IDLE and hmastlock is 0.
- R10: Read data is taken only at the edge where hready is high in the read data phase. hrdata values present while hready is low do not affect hwdata or old_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a read-modify-write |
| req_addr | input | ADDR_W | Target word address |
| req_op | input | 2 | Modify operation code |
| req_operand | input | DATA_W | Operand for the modify operation |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when the write completes |
| old_data | output | DATA_W | Word read by the last sequence |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Bus transfer type |
| hwrite | output | 1 | Bus write direction |
| hsize | output | 3 | Transfer size, fixed to DATA_W |
| hmastlock | output | 1 | Locked-sequence indicator |
| hwdata | output | DATA_W | Bus write data |
| hready | input | 1 | Bus transfer completion |
| hrdata | input | DATA_W | Bus read data |

## Verification
Directed sequences cover the semaphore case: a test-and-set on a clear word and then on a set word, which returns old 0 and then old 1. An increment of an all-ones word checks the wrap-around. A clear and a swap check the other two codes. Random sequences add wait states at each of the three phases, with changing garbage on hrdata while ready is low. This separates a design that holds its outputs and samples at the right edge from one that moves early or captures stale data. Start pulses given mid-sequence with a different address check that a running operation cannot be redirected.

// File: rtl/rmw_pkg.sv
`timescale 1ns/1ps
package rmw_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    OP_SWAP = 2'b00,
    OP_ADD  = 2'b01,
    OP_SET  = 2'b10,
    OP_CLR  = 2'b11
  } rmw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_REL
  } rmw_state_e;
endpackage

// File: rtl/rmw_seq_ctrl.sv
`timescale 1ns/1ps
module rmw_seq_ctrl
  import rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       hready,
  output rmw_state_e state_q,
  output rmw_state_e state_d,
  output logic       accept,
  output logic       capture,
  output logic       finish,
  output logic       busy
);
  assign accept  = (state_q == ST_IDLE) && start;
  assign capture = (state_q == ST_WR) && hready;
  assign finish  = (state_q == ST_REL) && hready;
  assign busy    = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start)  state_d = ST_RD;
      ST_RD:   if (hready) state_d = ST_WR;
      ST_WR:   if (hready) state_d = ST_REL;
      ST_REL:  if (hready) state_d = ST_IDLE;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // R8: an accepted request keeps the block busy until it finishes
  p_busy_until_finish_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish) |=> busy);

  // R7: busy drops right after the write data phase completes
  p_free_after_finish_r7: assert property (@(posedge clk) disable iff (rst)
    finish |=> !busy);
endmodule

// File: rtl/rmw_bus_drive.sv
`timescale 1ns/1ps
module rmw_bus_drive
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  rmw_state_e        state_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              hready,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic              hmastlock
);
  // Outputs are registered from the next state so they match the state register
  always_ff @(posedge clk) begin
    if (rst) begin
      htrans    <= TR_IDLE;
      hwrite    <= 1'b0;
      hmastlock <= 1'b0;
      haddr     <= '0;
    end else begin
      case (state_d)
        ST_RD: begin
          htrans    <= TR_NONSEQ;
          hwrite    <= 1'b0;
          hmastlock <= 1'b1;
        end
        ST_WR: begin
          htrans    <= TR_NONSEQ;
          hwrite    <= 1'b1;
          hmastlock <= 1'b1;
        end
        default: begin
          htrans    <= TR_IDLE;
          hwrite    <= 1'b0;
          hmastlock <= 1'b0;
        end
      endcase
      if (accept) haddr <= req_addr;
    end
  end

  p_read_issue_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (htrans == TR_NONSEQ && !hwrite && hmastlock && haddr == $past(req_addr)));

  p_write_follows_r3: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_NONSEQ && !hwrite && hready) |=>
      (htrans == TR_NONSEQ && hwrite && hmastlock && $stable(haddr)));

  p_release_lock_r4: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_NONSEQ && hwrite && hready) |=> (htrans == TR_IDLE && !hmastlock));

  p_hold_on_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (htrans != TR_IDLE && !hready) |=>
      ($stable(htrans) && $stable(haddr) && $stable(hwrite) && $stable(hmastlock)));

  p_idle_unlocked_r9: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_IDLE) |-> !hmastlock);
endmodule

// File: rtl/rmw_datapath.sv
`timescale 1ns/1ps
module rmw_datapath
  import rmw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic              finish,
  input  logic              in_wphase,
  input  rmw_op_e           req_op,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [DATA_W-1:0] hrdata,
  output logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] old_data,
  output logic              done
);
  rmw_op_e           op_q;
  logic [DATA_W-1:0] operand_q;
  logic [DATA_W-1:0] new_val;

  always_comb begin
    case (op_q)
      OP_SWAP: new_val = operand_q;
      OP_ADD:  new_val = hrdata + operand_q;
      OP_SET:  new_val = hrdata | operand_q;
      default: new_val = hrdata & ~operand_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= OP_SWAP;
      operand_q <= '0;
      hwdata    <= '0;
      old_data  <= '0;
      done      <= 1'b0;
    end else begin
      if (accept) begin
        op_q      <= req_op;
        operand_q <= req_operand;
      end
      if (capture) begin
        old_data <= hrdata;
        hwdata   <= new_val;
      end
      done <= finish;
    end
  end

  p_wdata_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (in_wphase && !finish) |=> $stable(hwdata));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_old_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!capture) |=> $stable(old_data));
endmodule

// File: rtl/ahb_locked_rmw.sv
`timescale 1ns/1ps
module ahb_locked_rmw
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] req_operand,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] old_data,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic              hmastlock,
  output logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic [DATA_W-1:0] hrdata
);
  localparam int BYTES_LOG2 = $clog2(DATA_W / 8);

  rmw_state_e state_q, state_d;
  logic       accept, capture, finish;

  assign hsize = 3'(BYTES_LOG2);

  rmw_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .hready  (hready),
    .state_q (state_q),
    .state_d (state_d),
    .accept  (accept),
    .capture (capture),
    .finish  (finish),
    .busy    (busy)
  );

  rmw_bus_drive #(.ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .accept    (accept),
    .req_addr  (req_addr),
    .hready    (hready),
    .haddr     (haddr),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .hmastlock (hmastlock)
  );

  rmw_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .capture     (capture),
    .finish      (finish),
    .in_wphase   (state_q == ST_REL),
    .req_op      (rmw_op_e'(req_op)),
    .req_operand (req_operand),
    .hrdata      (hrdata),
    .hwdata      (hwdata),
    .old_data    (old_data),
    .done        (done)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (htrans == TR_IDLE && !hmastlock && !done && !busy));
endmodule

// File: tb/test_ahb_locked_rmw.sv
`timescale 1ns/1ps
module test_ahb_locked_rmw;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_op = 2'b00;
  logic [DW-1:0] req_operand = '0;
  logic          busy, done, hwrite, hmastlock;
  logic [DW-1:0] old_data, hwdata;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic [2:0]    hsize;
  logic          hready = 1'b1;
  logic [DW-1:0] hrdata = '0;

  int n_vec = 0;
  int n_bad = 0;
  logic [DW-1:0] mem [16];

  always #10 clk = ~clk;

  ahb_locked_rmw #(.ADDR_W(AW), .DATA_W(DW)) i_ahb_locked_rmw (
    .clk(clk), .rst(rst), .start(start), .req_addr(req_addr), .req_op(req_op),
    .req_operand(req_operand), .busy(busy), .done(done), .old_data(old_data),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hmastlock(hmastlock), .hwdata(hwdata), .hready(hready), .hrdata(hrdata)
  );

  function automatic logic [DW-1:0] exp_new(input logic [1:0] op,
                                            input logic [DW-1:0] oldv,
                                            input logic [DW-1:0] opnd);
    case (op)
      2'b00:   return opnd;
      2'b01:   return oldv + opnd;
      2'b10:   return oldv | opnd;
      default: return oldv & ~opnd;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_held(input logic [AW-1:0] a, input logic [1:0] tr,
                            input logic wr, input logic lk);
    chk("R6 htrans held", 64'(htrans), 64'(tr));
    chk("R6 haddr held", 64'(haddr), 64'(a));
    chk("R6 hwrite held", 64'(hwrite), 64'(wr));
    chk("R6 lock held", 64'(hmastlock), 64'(lk));
  endtask

  // One full locked sequence; w1..w3 are wait states in each phase
  task automatic run_rmw(input int idx, input logic [1:0] op, input logic [DW-1:0] opnd,
                         input int w1, input int w2, input int w3, input bit poke);
    logic [AW-1:0] a;
    logic [DW-1:0] oldv, newv;
    a    = 32'h0000_0100 + 32'(idx * 4);
    oldv = mem[idx];
    newv = exp_new(op, oldv, opnd);
    req_addr = a; req_op = op; req_operand = opnd; start = 1'b1; hready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 htrans", 64'(htrans), 64'h2);
    chk("R2 hwrite", 64'(hwrite), 64'h0);
    chk("R2 lock", 64'(hmastlock), 64'h1);
    chk("R2 haddr", 64'(haddr), 64'(a));
    chk("R2 busy", 64'(busy), 64'h1);
    for (int i = 0; i < w1; i++) begin
      hready = 1'b0;
      if (poke) begin
        start = 1'b1; req_addr = a ^ 32'h40; req_op = ~op; req_operand = ~opnd;
      end
      @(negedge clk);
      check_held(a, 2'b10, 1'b0, 1'b1);
    end
    start = 1'b0;
    hready = 1'b1;
    @(negedge clk);
    chk("R3 htrans", 64'(htrans), 64'h2);
    chk("R3 hwrite", 64'(hwrite), 64'h1);
    chk("R3 lock", 64'(hmastlock), 64'h1);
    chk("R3 R8 haddr", 64'(haddr), 64'(a));
    for (int i = 0; i < w2; i++) begin
      hready = 1'b0;
      hrdata = $urandom();
      if (poke) begin
        start = 1'b1; req_addr = a ^ 32'h80;
      end
      @(negedge clk);
      check_held(a, 2'b10, 1'b1, 1'b1);
    end
    start = 1'b0;
    hready = 1'b1;
    hrdata = oldv;
    @(negedge clk);
    hrdata = $urandom();
    chk("R4 htrans idle", 64'(htrans), 64'h0);
    chk("R4 lock released", 64'(hmastlock), 64'h0);
    chk("R5 R10 hwdata", 64'(hwdata), 64'(newv));
    for (int i = 0; i < w3; i++) begin
      hready = 1'b0;
      @(negedge clk);
      chk("R4 hwdata stable", 64'(hwdata), 64'(newv));
      chk("R7 no early done", 64'(done), 64'h0);
    end
    hready = 1'b1;
    @(negedge clk);
    chk("R7 done", 64'(done), 64'h1);
    chk("R7 old_data", 64'(old_data), 64'(oldv));
    chk("R7 busy low", 64'(busy), 64'h0);
    mem[idx] = newv;
    @(negedge clk);
    chk("R7 done single", 64'(done), 64'h0);
    chk("R9 idle", 64'(htrans), 64'h0);
    chk("R9 unlocked", 64'(hmastlock), 64'h0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 16; i++) mem[i] = 32'h1111_1111 * 32'(i);
    repeat (3) @(negedge clk);
    chk("R1 htrans", 64'(htrans), 64'h0);
    chk("R1 lock", 64'(hmastlock), 64'h0);
    chk("R1 done", 64'(done), 64'h0);
    chk("R1 busy", 64'(busy), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset htrans", 64'(htrans), 64'h0);
    chk("R1 after reset busy", 64'(busy), 64'h0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 no request idle", 64'(htrans), 64'h0);
      chk("R9 no request unlocked", 64'(hmastlock), 64'h0);
    end
    // semaphore test-and-set: clear word, then already-set word
    mem[3] = 32'h0;
    run_rmw(3, 2'b10, 32'h1, 0, 0, 0, 1'b0);
    run_rmw(3, 2'b10, 32'h1, 1, 2, 1, 1'b0);
    chk("R5 semaphore value", 64'(mem[3]), 64'h1);
    // increment wrap
    mem[5] = 32'hFFFF_FFFF;
    run_rmw(5, 2'b01, 32'h1, 2, 0, 3, 1'b0);
    chk("R5 wrap", 64'(mem[5]), 64'h0);
    // clear bits and swap
    mem[7] = 32'hF0F0_F0F0;
    run_rmw(7, 2'b11, 32'h3030_0000, 0, 3, 0, 1'b0);
    run_rmw(9, 2'b00, 32'hDEAD_BEEF, 1, 1, 1, 1'b1);
    // random mix with waits and start pokes while busy (R8)
    for (int k = 0; k < 40; k++) begin
      int  idx;
      logic [1:0] op;
      logic [DW-1:0] opnd;
      idx  = int'($urandom_range(15, 0));
      op   = 2'($urandom_range(3, 0));
      opnd = ($urandom_range(3, 0) == 0) ? 32'h1 : $urandom();
      run_rmw(idx, op, opnd, int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
              int'($urandom_range(3, 0)), 1'($urandom_range(1, 0)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule